// File: doc/BRIEF.md
# Linear Chirp Quadrature Synthesizer

This block generates one pulse of a linear frequency sweep as quadrature samples at the full sample rate. A trigger captures four values: a start tuning word, a sweep-rate word, a pulse length in samples and a direction select. The block then runs two 32-bit accumulators in series. The frequency accumulator starts at the start word and moves by the sweep-rate word every sample. The phase accumulator adds the current frequency word every sample. The phase therefore grows quadratically with time, and the instantaneous frequency is the start frequency plus or minus the rate times the sample index. The rate word is normally chosen as bandwidth divided by pulse length.

The top bits of the phase address a small quarter-wave table, which returns signed sine and cosine samples. One flag shows that the generator is running. A second flag, one cycle later, marks each registered output sample. Between pulses both outputs are held at zero.

Top module: `chirp_gen`

## Requirements
- R1: While reset is asserted (rst_n low), and in the first cycle after it, sin_o and cos_o are 0 and sample_valid_o and pulse_active_o are 0.
- R2: A trigger (trig_i high at a rising edge) while idle with a nonzero length L raises pulse_active_o after that edge, for exactly L cycles. sample_valid_o is high for exactly L cycles, starting one cycle after pulse_active_o rises.
- R3: A trigger while idle with pulse_len_i equal to 0 is ignored: neither flag rises and the outputs stay 0.
- R4: A trigger while pulse_active_o is high is ignored. The running pulse keeps its length and its sample values.
- R5: The phase behind the valid sample with index n (n = 0 .. L-1) is n·F + s·R·n(n−1)/2 modulo 2^32. F is the start word and R the sweep-rate word. s is +1 when sweep_down_i was 0 at the trigger (rising sweep) and −1 when it was 1 (falling sweep).
- R6: start_word_i, sweep_rate_i, pulse_len_i and sweep_down_i are sampled only on an accepted trigger. Changing them during a pulse has no effect on that pulse.
- R7: With p the top 10 bits of the R5 phase, sin_o lies within 80 LSB of 32767·sin((2p+1)π/1024), and cos_o lies within 80 LSB of 32767·cos((2p+1)π/1024). Both are 16-bit two's complement.
- R8: Whenever sample_valid_o is low, sin_o and cos_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Pulse start request |
| start_word_i | input | 32 | Start frequency tuning word |
| sweep_rate_i | input | 32 | Per-sample change of the tuning word |
| pulse_len_i | input | 16 | Pulse length in samples |
| sweep_down_i | input | 1 | 1 selects a falling sweep |
| sin_o | output | 16 | Signed sine sample |
| cos_o | output | 16 | Signed cosine sample |
| sample_valid_o | output | 1 | Marks a valid output sample |
| pulse_active_o | output | 1 | Generator running |

## Verification
The assertions take for granted that reset is held for at least one clock edge before any trigger. They also assume the trigger and control words are stable around each rising edge. The unit-circle check further assumes that the table addresses are always in range, which holds for any 10-bit phase.

The stimulus changes inputs only on falling edges. It drops the trigger one cycle after raising it, except in the deliberate disturbance scenarios. Those keep the trigger high for two cycles in the middle of a pulse and alter every control word at the same time.

// File: rtl/chirp_pkg.sv
package chirp_pkg;

    // Quarter-wave magnitude for table entry idx, evaluated at the centre of the
    // phase bin using a rational sine approximation; the result is rounded.
    function automatic int quarter_sine(input int idx, input int phase_bits, input int amp_w);
        longint half_span;
        longint pos;
        longint prod;
        longint amp;
        longint denom;
        half_span = longint'(1) << phase_bits;
        pos       = 2 * longint'(idx) + 1;
        prod      = pos * (half_span - pos);
        amp       = (longint'(1) << (amp_w - 1)) - 1;
        denom     = (5 * half_span * half_span) / 4 - prod;
        return int'((amp * 4 * prod + denom / 2) / denom);
    endfunction

endpackage

// File: rtl/chirp_quarter_rom.sv
module chirp_quarter_rom #(
    parameter int IDX_W = 8,
    parameter int AMP_W = 16
) (
    input  logic [IDX_W-1:0] addr_a,
    input  logic [IDX_W-1:0] addr_b,
    output logic [AMP_W-2:0] mag_a,
    output logic [AMP_W-2:0] mag_b
);
    localparam int DEPTH      = 2 ** IDX_W;
    localparam int PHASE_BITS = IDX_W + 2;

    logic [AMP_W-2:0] table_q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        assign table_q[gi] = (AMP_W-1)'(chirp_pkg::quarter_sine(gi, PHASE_BITS, AMP_W));
    end

    assign mag_a = table_q[addr_a];
    assign mag_b = table_q[addr_b];
endmodule

// File: rtl/chirp_iq_map.sv
module chirp_iq_map #(
    parameter int PHASE_BITS = 10,
    parameter int AMP_W      = 16
) (
    input  logic [PHASE_BITS-1:0]   phase_i,
    output logic signed [AMP_W-1:0] sin_o,
    output logic signed [AMP_W-1:0] cos_o
);
    localparam int IDX_W = PHASE_BITS - 2;
    localparam longint FULL = (longint'(1) << (AMP_W - 1)) - 1;

    logic [1:0]       quad;
    logic [IDX_W-1:0] idx_fwd;
    logic [IDX_W-1:0] idx_rev;
    logic [IDX_W-1:0] addr_sin;
    logic [IDX_W-1:0] addr_cos;
    logic [AMP_W-2:0] mag_sin;
    logic [AMP_W-2:0] mag_cos;
    logic             neg_sin;
    logic             neg_cos;

    assign quad    = phase_i[PHASE_BITS-1 -: 2];
    assign idx_fwd = phase_i[IDX_W-1:0];
    assign idx_rev = ~idx_fwd;

    // odd quadrants run the table backwards; cosine is sine a quarter ahead
    assign addr_sin = quad[0] ? idx_rev : idx_fwd;
    assign addr_cos = quad[0] ? idx_fwd : idx_rev;
    assign neg_sin  = quad[1];
    assign neg_cos  = quad[1] ^ quad[0];

    chirp_quarter_rom #(.IDX_W(IDX_W), .AMP_W(AMP_W)) u_rom (
        .addr_a (addr_sin),
        .addr_b (addr_cos),
        .mag_a  (mag_sin),
        .mag_b  (mag_cos)
    );

    always_comb begin
        sin_o = neg_sin ? -$signed({1'b0, mag_sin}) : $signed({1'b0, mag_sin});
        cos_o = neg_cos ? -$signed({1'b0, mag_cos}) : $signed({1'b0, mag_cos});
    end

    // quadrature pair stays near the unit circle (within about 1 percent in power)
    always_comb begin
        longint sumsq;
        sumsq = longint'(sin_o) * longint'(sin_o) + longint'(cos_o) * longint'(cos_o);
        assert_unit_circle_R7: assert (sumsq * 100 >= FULL * FULL * 99 && sumsq * 100 <= FULL * FULL * 101)
            else $error("quadrature magnitude out of range");
    end
endmodule

// File: rtl/chirp_sweep.sv
module chirp_sweep #(
    parameter int ACC_W      = 32,
    parameter int LEN_W      = 16,
    parameter int PHASE_BITS = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trig_i,
    input  logic [ACC_W-1:0]      start_word_i,
    input  logic [ACC_W-1:0]      sweep_rate_i,
    input  logic [LEN_W-1:0]      pulse_len_i,
    input  logic                  sweep_down_i,
    output logic                  active_o,
    output logic [PHASE_BITS-1:0] phase_top_o
);
    typedef struct packed {
        logic [ACC_W-1:0] freq;
        logic [ACC_W-1:0] phase;
        logic [ACC_W-1:0] rate;
        logic             down;
        logic [LEN_W-1:0] remaining;
        logic             active;
    } sweep_t;

    sweep_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.active) begin
            s_d.phase     = s_q.phase + s_q.freq;
            s_d.freq      = s_q.down ? (s_q.freq - s_q.rate) : (s_q.freq + s_q.rate);
            s_d.remaining = s_q.remaining - 1'b1;
            if (s_q.remaining == LEN_W'(1)) begin
                s_d.active = 1'b0;
            end
        end else if (trig_i && pulse_len_i != '0) begin
            s_d.freq      = start_word_i;
            s_d.phase     = '0;
            s_d.rate      = sweep_rate_i;
            s_d.down      = sweep_down_i;
            s_d.remaining = pulse_len_i;
            s_d.active    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active_o    = s_q.active;
    assign phase_top_o = s_q.phase[ACC_W-1 -: PHASE_BITS];

    assert_len_zero_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.active && trig_i && pulse_len_i == '0) |=> !s_q.active);

    assert_busy_trig_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && trig_i) |=> ($stable(s_q.rate) && $stable(s_q.down)));

    assert_load_on_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.active) |-> (s_q.phase == '0 && s_q.freq == $past(start_word_i)));

    assert_end_on_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.active) |-> $past(s_q.remaining) == LEN_W'(1));
endmodule

// File: rtl/chirp_gen.sv
module chirp_gen #(
    parameter int ACC_W      = 32,
    parameter int LEN_W      = 16,
    parameter int PHASE_BITS = 10,
    parameter int AMP_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic [ACC_W-1:0] start_word_i,
    input  logic [ACC_W-1:0] sweep_rate_i,
    input  logic [LEN_W-1:0] pulse_len_i,
    input  logic             sweep_down_i,
    output logic [AMP_W-1:0] sin_o,
    output logic [AMP_W-1:0] cos_o,
    output logic             sample_valid_o,
    output logic             pulse_active_o
);
    typedef struct packed {
        logic             valid;
        logic [AMP_W-1:0] sin;
        logic [AMP_W-1:0] cos;
    } out_t;

    logic                    running;
    logic [PHASE_BITS-1:0]   phase_top;
    logic signed [AMP_W-1:0] sin_raw;
    logic signed [AMP_W-1:0] cos_raw;
    out_t                    o_d, o_q;

    chirp_sweep #(.ACC_W(ACC_W), .LEN_W(LEN_W), .PHASE_BITS(PHASE_BITS)) u_sweep (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_i       (trig_i),
        .start_word_i (start_word_i),
        .sweep_rate_i (sweep_rate_i),
        .pulse_len_i  (pulse_len_i),
        .sweep_down_i (sweep_down_i),
        .active_o     (running),
        .phase_top_o  (phase_top)
    );

    chirp_iq_map #(.PHASE_BITS(PHASE_BITS), .AMP_W(AMP_W)) u_map (
        .phase_i (phase_top),
        .sin_o   (sin_raw),
        .cos_o   (cos_raw)
    );

    always_comb begin
        o_d       = '0;
        o_d.valid = running;
        if (running) begin
            o_d.sin = sin_raw;
            o_d.cos = cos_raw;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign sin_o          = o_q.sin;
    assign cos_o          = o_q.cos;
    assign sample_valid_o = o_q.valid;
    assign pulse_active_o = running;

    assert_idle_outputs_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid_o |-> (sin_o == '0 && cos_o == '0));

    assert_valid_lags_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid_o == $past(pulse_active_o));
endmodule

// File: tb/chirp_gen_tb.sv
module chirp_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic [31:0] start_w = '0;
    logic [31:0] rate_w = '0;
    logic [15:0] len_w = '0;
    logic        down = 1'b0;
    logic [15:0] sin_s, cos_s;
    logic        valid, active;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    chirp_gen u_dut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .start_word_i(start_w),
        .sweep_rate_i(rate_w), .pulse_len_i(len_w), .sweep_down_i(down),
        .sin_o(sin_s), .cos_o(cos_s), .sample_valid_o(valid), .pulse_active_o(active)
    );

    task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(valid == 1'b0, req, "valid low", valid, 0);
        check(active == 1'b0, req, "active low", active, 0);
        check(sin_s == 16'd0 && cos_s == 16'd0, req, "outputs zero", {sin_s, cos_s}, 0);
    endtask

    task automatic check_sample(input int n, input logic [31:0] f, input logic [31:0] r, input bit dn);
        logic [31:0] tri_n, ph;
        int          p;
        real         ang, es, ec, ds, dc;
        tri_n = 32'(n * (n - 1) / 2);
        ph    = 32'(n) * f + (dn ? -(r * tri_n) : r * tri_n);
        p     = int'(ph[31:22]);
        ang   = (2.0 * p + 1.0) * 3.14159265358979 / 1024.0;
        es    = 32767.0 * $sin(ang);
        ec    = 32767.0 * $cos(ang);
        ds    = $itor($signed(sin_s)) - es;
        dc    = $itor($signed(cos_s)) - ec;
        check(ds < 80.0 && ds > -80.0, "R5/R7", $sformatf("sin sample %0d", n), $signed(sin_s), longint'(es));
        check(dc < 80.0 && dc > -80.0, "R5/R7", $sformatf("cos sample %0d", n), $signed(cos_s), longint'(ec));
    endtask

    // run one pulse; if disturb, a second trigger and new controls arrive mid-pulse
    task automatic run_pulse(input logic [31:0] f, input logic [31:0] r, input int len, input bit dn, input bit disturb);
        start_w = f; rate_w = r; len_w = 16'(len); down = dn; trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        check(active == 1'b1, "R2", "active after trigger", active, 1);
        check(valid == 1'b0, "R2", "valid lags active", valid, 0);
        for (int n = 0; n < len; n++) begin
            if (disturb && n == len / 2) begin
                trig = 1'b1; start_w = ~f; rate_w = r + 32'h0100_0000; len_w = 16'(len + 7); down = ~dn;
            end
            if (disturb && n == len / 2 + 2) trig = 1'b0;
            @(negedge clk);
            check(valid == 1'b1, "R2", $sformatf("valid at sample %0d", n), valid, 1);
            check(active == (n < len - 1), disturb ? "R4" : "R2", $sformatf("active at sample %0d", n), active, n < len - 1);
            check_sample(n, f, r, dn);
        end
        trig = 1'b0;
        @(negedge clk);
        check_idle(disturb ? "R4/R6" : "R8");
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");
    endtask

    task automatic t_zero_len();
        start_w = 32'h1000_0000; len_w = 16'd0; trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check_idle("R3");
        end
    endtask

    initial begin
        t_reset();
        run_pulse(32'h0200_0000, 32'h0004_0000, 40, 1'b0, 1'b0);  // rising sweep
        run_pulse(32'h6000_0000, 32'h0080_0000, 25, 1'b1, 1'b0);  // falling sweep
        run_pulse(32'h4000_0000, 32'h0000_0000, 8, 1'b0, 1'b0);   // constant tone
        run_pulse(32'h1234_5678, 32'h9ABC_DEF0, 1, 1'b0, 1'b0);   // single sample
        t_zero_len();
        run_pulse(32'h0800_0000, 32'h0030_0000, 20, 1'b0, 1'b1);  // R4 R6 disturbance
        run_pulse(32'hF000_0000, 32'h0200_0000, 30, 1'b1, 1'b1);  // R4 R6 falling
        run_pulse(32'hFFFF_0000, 32'h0123_4567, 50, 1'b0, 1'b0);  // accumulator wrap
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule